// File: doc/BRIEF.md
# S-record stream loader

This block takes an ASCII character stream, one character per accepted valid/ready transfer, and decodes it as a sequence of S-records. A record starts with `S`, then a record-type digit, a two-digit byte count, a big-endian address of two, three or four bytes, a run of data bytes and one checksum byte. Every field after the type digit is written in hexadecimal.

For the data-carrying record types the loader issues one byte write per data byte. Each write goes to the record address plus the byte's position within the record. The writes leave the block as the bytes arrive, before the checksum has been seen. The checksum is accumulated on the fly and compared at the end of the record. A termination record, whose checksum must be good, latches its start address and raises a one-cycle done pulse. Bad characters, bad checksums and malformed headers set a sticky error flag. After any of these the loader goes back to hunting for the next `S`.

Top module: `srec_loader`

## Requirements
- R1: After reset there are no write strobes, load_done and load_err are 0, start_addr is 0 and in_ready is 1.
- R2: In a type-1 record the address is 16 bits (4 hex digits). Data byte k is written to address+k. The write strobe appears in the cycle after the clock edge that accepts the data byte's second hex digit.
- R3: Type-2 records carry a 24-bit address (6 digits) and type-3 records a 32-bit address (8 digits). Both write their data like type 1.
- R4: Hex digits are accepted in both upper case and lower case.
- R5: Type 0 (16-bit address), type 5 (16-bit) and type 6 (24-bit) are parsed and checksum-checked but produce no writes.
- R6: Types 7, 8 and 9 terminate with a 32-, 24- and 16-bit start address. When the checksum is good, start_addr takes that address and load_done is high for exactly one cycle.
- R7: The checksum byte must equal the bitwise inverse of the low 8 bits of the sum of the count, address and data bytes. On a mismatch load_err is set and no done pulse is given. Writes already issued are not withdrawn.
- R8: A non-hex character after the type digit sets load_err and abandons the record. A following well-formed record is loaded normally.
- R9: Between records, CR (0x0D) and LF (0x0A) are ignored. Any other character other than `S` (0x53) between records sets load_err.
- R10: A type character that is not a decimal digit, or the reserved type 4, sets load_err.
- R11: A byte count smaller than the address length plus one sets load_err and abandons the record.
- R12: in_ready is always 1. A character is consumed only in a cycle where in_valid is 1. in_data is ignored otherwise.
- R13: load_err is sticky and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character on in_data is valid |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Loader accepts a character (always 1) |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data byte |
| load_err | output | 1 | Sticky error flag |
| load_done | output | 1 | One-cycle pulse on a good termination record |
| start_addr | output | ADDR_W | Start address from the last good termination record |

## Verification
The hardest situation to reach is a record that fails partway through. Some writes have already left the block, and then a bad character or bad checksum arrives. A correct record then has to follow without leftover state from the abandoned one. The bench builds records byte by byte from parameters, so it can corrupt the checksum or cut a record short with a non-hex character after a chosen number of data bytes. It then sends a clean record straight after and compares the write log of both.

Near-exhaustive sweeps cover the three address widths against data lengths 0 to 8. They alternate letter case and insert idle gaps carrying junk on in_data, so that address arithmetic, byte-count sequencing and the valid qualifier are all exercised.

// File: rtl/srec_pkg.sv
package srec_pkg;

    localparam int CHAR_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_CSUM
    } st_e;

    // Properties of a record type digit
    typedef struct packed {
        logic       legal;
        logic       writes;
        logic       term;
        logic [2:0] alen;   // address length in bytes
    } kind_t;

endpackage

// File: rtl/srec_hexdec.sv
module srec_hexdec
    import srec_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic              is_dec,
    output logic              is_start,
    output logic              is_eol,
    output logic [3:0]        nib
);
    always_comb begin
        is_dec   = (ch >= 8'h30) && (ch <= 8'h39);
        is_start = (ch == 8'h53);
        is_eol   = (ch == 8'h0D) || (ch == 8'h0A);
        is_hex   = is_dec;
        nib      = ch[3:0];
        if (((ch >= 8'h41) && (ch <= 8'h46)) || ((ch >= 8'h61) && (ch <= 8'h66))) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/srec_kind.sv
module srec_kind
    import srec_pkg::*;
(
    input  logic [3:0] digit,
    output kind_t      kind
);
    always_comb begin
        kind = '0;
        case (digit)
            4'd0: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b0, alen: 3'd2};
            4'd1: kind = '{legal: 1'b1, writes: 1'b1, term: 1'b0, alen: 3'd2};
            4'd2: kind = '{legal: 1'b1, writes: 1'b1, term: 1'b0, alen: 3'd3};
            4'd3: kind = '{legal: 1'b1, writes: 1'b1, term: 1'b0, alen: 3'd4};
            4'd5: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b0, alen: 3'd2};
            4'd6: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b0, alen: 3'd3};
            4'd7: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b1, alen: 3'd4};
            4'd8: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b1, alen: 3'd3};
            4'd9: kind = '{legal: 1'b1, writes: 1'b0, term: 1'b1, alen: 3'd2};
            default: kind = '0;
        endcase
    end
endmodule

// File: rtl/srec_loader.sv
module srec_loader
    import srec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CHAR_W-1:0]   in_data,
    output logic                in_ready,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                load_err,
    output logic                load_done,
    output logic [ADDR_W-1:0]   start_addr
);
    localparam int SHIFT_HI = ADDR_W - BYTE_W - 1;

    typedef struct packed {
        st_e                st;
        logic               hi;
        logic [3:0]         nib;
        kind_t              kind;
        logic [BYTE_W-1:0]  remain;
        logic [2:0]         alen_left;
        logic [BYTE_W-1:0]  sum;
        logic [ADDR_W-1:0]  addr;
        logic               wr_en;
        logic [ADDR_W-1:0]  wr_addr;
        logic [BYTE_W-1:0]  wr_data;
        logic               err;
        logic               done;
        logic [ADDR_W-1:0]  start;
    } regs_t;

    regs_t q, d;

    logic       c_hex, c_dec, c_start, c_eol;
    logic [3:0] c_nib;
    kind_t      c_kind;

    srec_hexdec u_hex (
        .ch       (in_data),
        .is_hex   (c_hex),
        .is_dec   (c_dec),
        .is_start (c_start),
        .is_eol   (c_eol),
        .nib      (c_nib)
    );

    srec_kind u_kind (
        .digit (c_nib),
        .kind  (c_kind)
    );

    logic [BYTE_W-1:0] byte_v;
    logic [BYTE_W-1:0] sum_nx;
    logic [BYTE_W-1:0] min_cnt;

    always_comb begin
        byte_v  = {q.nib, c_nib};
        sum_nx  = q.sum + byte_v;
        min_cnt = {5'd0, q.kind.alen} + 8'd1;
        d       = q;
        d.wr_en = 1'b0;
        d.done  = 1'b0;
        if (in_valid) begin
            case (q.st)
                ST_IDLE: begin
                    d.hi = 1'b0;
                    if (c_start)     d.st  = ST_TYPE;
                    else if (!c_eol) d.err = 1'b1;
                end
                ST_TYPE: begin
                    if (c_dec && c_kind.legal) begin
                        d.kind = c_kind;
                        d.st   = ST_COUNT;
                    end else begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end
                end
                default: begin
                    if (!c_hex) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else if (!q.hi) begin
                        d.hi  = 1'b1;
                        d.nib = c_nib;
                    end else begin
                        d.hi = 1'b0;
                        case (q.st)
                            ST_COUNT: begin
                                d.sum       = byte_v;
                                d.remain    = byte_v;
                                d.alen_left = q.kind.alen;
                                d.addr      = '0;
                                if (byte_v < min_cnt) begin
                                    d.err = 1'b1;
                                    d.st  = ST_IDLE;
                                end else begin
                                    d.st = ST_ADDR;
                                end
                            end
                            ST_ADDR: begin
                                d.addr      = {q.addr[SHIFT_HI:0], byte_v};
                                d.sum       = sum_nx;
                                d.remain    = q.remain - 8'd1;
                                d.alen_left = q.alen_left - 3'd1;
                                if (q.alen_left == 3'd1)
                                    d.st = (q.remain == 8'd2) ? ST_CSUM : ST_DATA;
                            end
                            ST_DATA: begin
                                if (q.kind.writes) begin
                                    d.wr_en   = 1'b1;
                                    d.wr_addr = q.addr;
                                    d.wr_data = byte_v;
                                end
                                d.addr   = q.addr + 1'b1;
                                d.sum    = sum_nx;
                                d.remain = q.remain - 8'd1;
                                if (q.remain == 8'd2) d.st = ST_CSUM;
                            end
                            default: begin
                                d.st = ST_IDLE;
                                if (sum_nx != 8'hFF) begin
                                    d.err = 1'b1;
                                end else if (q.kind.term) begin
                                    d.done  = 1'b1;
                                    d.start = q.addr;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready   = 1'b1;
    assign wr_en      = q.wr_en;
    assign wr_addr    = q.wr_addr;
    assign wr_data    = q.wr_data;
    assign load_err   = q.err;
    assign load_done  = q.done;
    assign start_addr = q.start;

    // R2: a write only follows an accepted character
    a_r2_write_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    // R6: done is a single-cycle pulse, caused by an accepted character
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);
    a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> $past(in_valid));
    a_r6_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && wr_en));

    // R13: error flag is sticky
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    // R12: never back-pressures
    a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready);

endmodule

// File: tb/tb_srec_loader.sv
module tb_srec_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        load_err;
    logic        load_done;
    logic [31:0] start_addr;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    srec_loader #(.ADDR_W(32)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_err   (load_err),
        .load_done  (load_done),
        .start_addr (start_addr)
    );

    // Event log sampled away from the active edge
    logic [31:0] log_a [0:511];
    logic [7:0]  log_d [0:511];
    int          wr_total = 0;
    int          done_total = 0;
    int          ready_low = 0;

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wr_total < 512) begin
                log_a[wr_total] = wr_addr;
                log_d[wr_total] = wr_data;
            end
            wr_total = wr_total + 1;
        end
        if (rst_n && load_done) done_total = done_total + 1;
        if (in_ready !== 1'b1) ready_low = ready_low + 1;
    end

    logic [7:0] tdat [0:15];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] v, input bit lo);
        if (v < 4'd10) return 8'h30 + {4'd0, v};
        return (lo ? 8'h61 : 8'h41) + {4'd0, v} - 8'd10;
    endfunction

    function automatic int alen_of(input int typ);
        case (typ)
            2, 6, 8: return 3;
            3, 7:    return 4;
            default: return 2;
        endcase
    endfunction

    task automatic put(input logic [7:0] c, input int gap);
        for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0;
            in_data  = 8'h47;
            @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_data  = c;
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = 8'h58;
    endtask

    task automatic put_byte(input logic [7:0] b, input bit lo, input int gap);
        put(hexc(b[7:4], lo), gap);
        put(hexc(b[3:0], lo), gap);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic send_rec(input int typ, input logic [31:0] a, input int n,
                            input bit lo, input int gap, input bit bad);
        int al;
        logic [7:0] cnt, sum, cs;
        al  = alen_of(typ);
        cnt = 8'(al + n + 1);
        sum = cnt;
        put(8'h53, gap);
        put(8'h30 + 8'(typ), gap);
        put_byte(cnt, lo, gap);
        for (int i = al - 1; i >= 0; i--) begin
            put_byte(a[8*i +: 8], lo, gap);
            sum = sum + a[8*i +: 8];
        end
        for (int i = 0; i < n; i++) begin
            put_byte(tdat[i], lo, gap);
            sum = sum + tdat[i];
        end
        cs = ~sum;
        if (bad) cs = cs ^ 8'h01;
        put_byte(cs, lo, gap);
        put(8'h0D, 0);
        put(8'h0A, 0);
        idle(2);
    endtask

    task automatic check_writes(input string tag, input int base, input int n, input logic [31:0] a);
        chk({tag, " write count"}, 32'(wr_total - base), 32'(n));
        for (int i = 0; i < n; i++) begin
            chk({tag, " addr"}, log_a[base + i], a + 32'(i));
            chk({tag, " data"}, {24'd0, log_d[base + i]}, {24'd0, tdat[i]});
        end
    endtask

    initial begin
        int base, dbase;
        logic [31:0] a;
        int masks [1:3];
        masks[1] = 32'h0000FFFF; masks[2] = 32'h00FFFFFF; masks[3] = 32'hFFFFFFFF;

        do_reset;
        // R1: reset state
        chk("R1 wr_en", {31'd0, wr_en}, 0);
        chk("R1 load_done", {31'd0, load_done}, 0);
        chk("R1 load_err", {31'd0, load_err}, 0);
        chk("R1 start_addr", start_addr, 0);
        chk("R1 in_ready", {31'd0, in_ready}, 1);

        // R2 R3 R4 R12: sweep of write types, lengths, case and gaps
        for (int typ = 1; typ <= 3; typ++) begin
            for (int n = 0; n <= 8; n++) begin
                a = (32'h9E3779B1 * 32'(n + 1) + 32'h01010101 * 32'(typ)) & masks[typ];
                for (int i = 0; i < n; i++) tdat[i] = 8'(n * 29 + i * 37 + typ);
                base = wr_total;
                send_rec(typ, a, n, n[0], n % 3, 1'b0);
                check_writes(typ == 1 ? "R2" : (n[0] ? "R4" : "R3"), base, n, a);
                chk("R12 no error with gapped input", {31'd0, load_err}, 0);
            end
        end
        chk("R12 in_ready held high", 32'(ready_low), 0);

        // R5: header and count records make no writes
        for (int i = 0; i < 4; i++) tdat[i] = 8'h41 + 8'(i);
        base = wr_total;
        send_rec(0, 32'h0000, 4, 1'b0, 0, 1'b0);
        send_rec(5, 32'h001B, 0, 1'b1, 0, 1'b0);
        send_rec(6, 32'h012345, 0, 1'b0, 0, 1'b0);
        chk("R5 no writes", 32'(wr_total - base), 0);
        chk("R5 no error", {31'd0, load_err}, 0);

        // R6: terminators
        dbase = done_total;
        send_rec(9, 32'h00001234, 0, 1'b0, 0, 1'b0);
        chk("R6 S9 done", 32'(done_total - dbase), 1);
        chk("R6 S9 start", start_addr, 32'h00001234);
        send_rec(8, 32'h00ABCDEF, 0, 1'b1, 1, 1'b0);
        chk("R6 S8 done", 32'(done_total - dbase), 2);
        chk("R6 S8 start", start_addr, 32'h00ABCDEF);
        send_rec(7, 32'hFEDC0042, 0, 1'b0, 0, 1'b0);
        chk("R6 S7 done", 32'(done_total - dbase), 3);
        chk("R6 S7 start", start_addr, 32'hFEDC0042);
        chk("R9 CR LF ignored", {31'd0, load_err}, 0);

        // R7: bad checksum on data record keeps writes, sets error
        tdat[0] = 8'h5A; tdat[1] = 8'hC3;
        base = wr_total;
        send_rec(1, 32'h00002000, 2, 1'b0, 0, 1'b1);
        check_writes("R7", base, 2, 32'h00002000);
        chk("R7 error set", {31'd0, load_err}, 1);
        dbase = done_total;
        send_rec(9, 32'h00000777, 0, 1'b0, 0, 1'b1);
        chk("R7 no done on bad sum", 32'(done_total - dbase), 0);
        chk("R7 start kept", start_addr, 32'hFEDC0042);
        // R13: sticky across a good record
        send_rec(9, 32'h00000888, 0, 1'b0, 0, 1'b0);
        chk("R13 error sticky", {31'd0, load_err}, 1);
        chk("R13 good record after error", start_addr, 32'h00000888);

        // R8: non-hex inside a record, then recovery
        do_reset;
        base = wr_total;
        put(8'h53, 0); put(8'h31, 0);
        put_byte(8'h05, 1'b0, 0);
        put_byte(8'h00, 1'b0, 0); put_byte(8'h10, 1'b0, 0);
        put_byte(8'hAB, 1'b0, 0);
        put(8'h47, 0);
        idle(2);
        chk("R8 error set", {31'd0, load_err}, 1);
        chk("R8 partial write count", 32'(wr_total - base), 1);
        chk("R8 partial write addr", log_a[base], 32'h00000010);
        base = wr_total;
        for (int i = 0; i < 3; i++) tdat[i] = 8'h90 + 8'(i);
        send_rec(2, 32'h00300000, 3, 1'b1, 0, 1'b0);
        check_writes("R8 recovery", base, 3, 32'h00300000);

        // R9: junk between records
        do_reset;
        put(8'h0D, 0); put(8'h0A, 0); idle(1);
        chk("R9 CR LF no error", {31'd0, load_err}, 0);
        put(8'h58, 0); idle(1);
        chk("R9 junk sets error", {31'd0, load_err}, 1);

        // R10: bad type characters
        do_reset;
        put(8'h53, 0); put(8'h34, 0); idle(1);
        chk("R10 type 4 error", {31'd0, load_err}, 1);
        do_reset;
        put(8'h53, 0); put(8'h41, 0); idle(1);
        chk("R10 non-digit type error", {31'd0, load_err}, 1);

        // R11: byte count too small
        do_reset;
        base = wr_total;
        put(8'h53, 0); put(8'h31, 0); put_byte(8'h02, 1'b0, 0); idle(1);
        chk("R11 short count error", {31'd0, load_err}, 1);
        chk("R11 no writes", 32'(wr_total - base), 0);
        do_reset;
        send_rec(5, 32'h0000, 0, 1'b0, 0, 1'b0);
        chk("R11 minimal count accepted", {31'd0, load_err}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule